// File: doc/BRIEF.md
# Programmable Sum-of-Products Evaluator

This block computes a single output bit as an OR of up to DEPTH product terms over a WIDTH-bit input vector. Each product term is an AND of input literals. For every input the term holds one enable for the true literal and one for the complemented literal. A term also carries a valid flag that decides whether it takes part in the OR. Any single-output Boolean function of the inputs can be loaded, given enough terms. Several different tables can encode the same function.

Software or a neighbouring controller loads the table through a word-addressed write port, one whole product term per write. The table lives in flip-flops, so the evaluation path is pure combinational logic from the input vector and the stored table. The parameter REGISTER_OUT selects whether the result is taken straight from that logic or through one output flip-flop.

Top module: `sop_eval`

## Requirements
- R1: `y_out` is the OR, over every term whose valid flag is set, of the AND of that term's enabled literals evaluated on `a_in`.
- R2: Field layout of a term word (TW = 2×WIDTH bits): bit TW-1-2i enables the true literal of input i and bit TW-2-2i enables its complement. With WIDTH=3, loading 6'b010000 into term 0 and 6'b001001 into term 1 (both valid) gives y = ~a[0] | (a[1] & ~a[2]).
- R3: A valid term with no literal enabled evaluates to 1, so it forces the output to 1.
- R4: A term that enables both the true and the complemented literal of the same input evaluates to 0 for every input value.
- R5: A term written with `cfg_valid`=0 contributes nothing. When no term is valid, the output is 0.
- R6: A write with `cfg_we`=1 replaces only the term and valid flag at `cfg_addr`, at the rising clock edge. All other terms keep their contents.
- R7: A write to an address at or above DEPTH changes no term.
- R8: While `rst_n` is low, every term and valid flag is cleared and `y_out` is 0. The output stays 0 until a term is written.
- R9: With REGISTER_OUT=1, `y_out` changes only at a rising clock edge, and it shows the function of the input and table as they were before that edge. With REGISTER_OUT=0, `y_out` follows `a_in` and the table without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| cfg_we | input | 1 | Term write strobe |
| cfg_addr | input | AW (clog2 DEPTH, min 1) | Index of the term to write |
| cfg_valid | input | 1 | Valid flag stored with the term |
| cfg_data | input | 2×WIDTH | Literal enables of the term, laid out as in R2 |
| a_in | input | WIDTH | Input vector |
| y_out | output | 1 | Function result |

## Verification
The bench aims at these corner cases:
- An empty valid term, which a design that ANDs over a zero-initialised accumulator would read as 0 instead of 1.
- A contradictory term, which a design that lets one literal enable mask the other would leave live.
- Writes to addresses past DEPTH, which a design that truncates the address would alias onto a real term.
- Invalid terms, which must not leak into the OR.
- The example table from R2, swept over all eight inputs to catch a design that swaps the pair order or the term order.
- The output latency, checked at the half cycle after an input change: a registered design that leaks its combinational value, or adds a second stage, shows up there.
- Random tables, each swept over every input value, against a behavioural model.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Bit position of the true-literal enable of input i in a term word
  function automatic int pos_true(input int width, input int i);
    return 2 * width - 1 - 2 * i;
  endfunction

  // Bit position of the complemented-literal enable of input i
  function automatic int pos_comp(input int width, input int i);
    return 2 * width - 2 - 2 * i;
  endfunction

endpackage

// File: rtl/sop_term_store.sv
module sop_term_store #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 5,
  parameter int AW    = 3,
  localparam int TW   = 2 * WIDTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic                     cfg_valid,
  input  logic [TW-1:0]            cfg_data,
  output logic [DEPTH-1:0][TW-1:0] term_q,
  output logic [DEPTH-1:0]         valid_q
);

  logic [DEPTH-1:0] wen;

  for (genvar k = 0; k < DEPTH; k++) begin : g_term
    // next-state: per-term clock enable
    always_comb begin
      wen[k] = cfg_we && (cfg_addr == AW'(k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        term_q[k]  <= '0;
        valid_q[k] <= 1'b0;
      end else if (wen[k]) begin
        term_q[k]  <= cfg_data;
        valid_q[k] <= cfg_valid;
      end
    end
  end

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
  parameter int WIDTH = 4,
  localparam int TW   = 2 * WIDTH
) (
  input  logic [TW-1:0]    term,
  input  logic             valid,
  input  logic [WIDTH-1:0] a,
  output logic             hit
);

  logic [WIDTH-1:0] lit_ok;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lit
    // a literal fails if its true enable meets a 0 or its complement enable meets a 1
    assign lit_ok[i] = ~((term[sop_pkg::pos_true(WIDTH, i)] & ~a[i]) |
                         (term[sop_pkg::pos_comp(WIDTH, i)] &  a[i]));
  end

  assign hit = valid & (&lit_ok);

endmodule

// File: rtl/sop_out_reg.sv
module sop_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/sop_eval.sv
module sop_eval #(
  parameter int WIDTH        = 4,
  parameter int DEPTH        = 5,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int TW          = 2 * WIDTH,
  localparam int AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic             cfg_valid,
  input  logic [TW-1:0]    cfg_data,
  input  logic [WIDTH-1:0] a_in,
  output logic             y_out
);

  logic [DEPTH-1:0][TW-1:0] term_q;
  logic [DEPTH-1:0]         valid_q;
  logic [DEPTH-1:0]         term_hit;
  logic                     y_comb;

  sop_term_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_valid(cfg_valid),
    .cfg_data (cfg_data),
    .term_q   (term_q),
    .valid_q  (valid_q)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_prod
    sop_term_eval #(.WIDTH(WIDTH)) eval_i (
      .term (term_q[k]),
      .valid(valid_q[k]),
      .a    (a_in),
      .hit  (term_hit[k])
    );
  end

  assign y_comb = |term_hit;

  if (REGISTER_OUT) begin : g_reg
    sop_out_reg out_i (.clk(clk), .rst_n(rst_n), .d(y_comb), .q(y_out));
  end else begin : g_comb
    assign y_out = y_comb;
  end

endmodule

// File: rtl/sop_eval_chk.sv
module sop_eval_chk #(
  parameter int WIDTH        = 4,
  parameter int DEPTH        = 5,
  parameter bit REGISTER_OUT = 1'b1,
  localparam int TW          = 2 * WIDTH,
  localparam int AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [AW-1:0]            cfg_addr,
  input logic                     cfg_valid,
  input logic [TW-1:0]            cfg_data,
  input logic [WIDTH-1:0]         a_in,
  input logic                     y_out,
  input logic [DEPTH-1:0][TW-1:0] term_q,
  input logic [DEPTH-1:0]         valid_q,
  input logic [DEPTH-1:0]         term_hit
);

  logic wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_seen <= 1'b0;
    else if (cfg_we) wr_seen <= 1'b1;
  end

  // R8: nothing written since reset means a zero output
  assert_clear_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> !y_out);

  // R7: writes past the last term leave the table alone
  assert_oob_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_addr) >= DEPTH) |=> ($stable(term_q) && $stable(valid_q)));

  for (genvar k = 0; k < DEPTH; k++) begin : g_k
    // R6: addressed term takes the written word
    assert_write_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(k)) |=>
        (term_q[k] == $past(cfg_data) && valid_q[k] == $past(cfg_valid)));

    // R6: other terms keep their contents
    assert_write_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == AW'(k)) |=> ($stable(term_q[k]) && $stable(valid_q[k])));

    // R3: an empty valid term is always true
    assert_empty_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q[k] && term_q[k] == '0) |-> term_hit[k]);

    // R5: an invalid term never fires
    assert_invalid_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q[k] |-> !term_hit[k]);

    for (genvar i = 0; i < WIDTH; i++) begin : g_i
      // R4: both polarities of one input make the term false
      assert_contradiction_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (term_q[k][sop_pkg::pos_true(WIDTH, i)] && term_q[k][sop_pkg::pos_comp(WIDTH, i)])
          |-> !term_hit[k]);
    end
  end

  if (REGISTER_OUT) begin : g_reg_chk
    // R9: quiet input and table for two cycles keeps the registered output still
    assert_reg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && !$past(cfg_we, 2) && $stable(a_in)) |=> $stable(y_out));
  end else begin : g_comb_chk
    // R9: combinational output only moves with the input or the table
    assert_comb_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && $stable(a_in)) |-> $stable(y_out));
  end

endmodule

bind sop_eval sop_eval_chk #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .REGISTER_OUT(REGISTER_OUT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_valid(cfg_valid),
  .cfg_data (cfg_data),
  .a_in     (a_in),
  .y_out    (y_out),
  .term_q   (term_q),
  .valid_q  (valid_q),
  .term_hit (term_hit)
);

// File: tb/sop_eval_tb_top.sv
module sop_eval_tb_top;

  // large instance: WIDTH 4, DEPTH 5, registered output
  logic       clk;
  logic       rst_n;
  logic       b_we;
  logic [2:0] b_addr;
  logic       b_valid;
  logic [7:0] b_data;
  logic [3:0] b_a;
  logic       b_y;

  // small instance: WIDTH 3, DEPTH 2, combinational output
  logic       s_we;
  logic       s_addr;
  logic       s_valid;
  logic [5:0] s_data;
  logic [2:0] s_a;
  logic       s_y;

  int checks   = 0;
  int failures = 0;
  bit cmp_en   = 0;
  bit done     = 0;

  sop_eval #(.WIDTH(4), .DEPTH(5), .REGISTER_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_addr(b_addr),
    .cfg_valid(b_valid), .cfg_data(b_data), .a_in(b_a), .y_out(b_y)
  );

  sop_eval #(.WIDTH(3), .DEPTH(2), .REGISTER_OUT(1'b0)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_addr(s_addr),
    .cfg_valid(s_valid), .cfg_data(s_data), .a_in(s_a), .y_out(s_y)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference state
  logic [7:0] mb_term [5];
  bit         mb_valid[5];
  logic [5:0] ms_term [2];
  bit         ms_valid[2];
  logic       exp_b;

  function automatic logic model_b(input logic [3:0] a);
    logic y = 1'b0;
    for (int k = 0; k < 5; k++) begin
      logic h = mb_valid[k];
      for (int i = 0; i < 4; i++) begin
        if (mb_term[k][7 - 2*i] && !a[i]) h = 1'b0;
        if (mb_term[k][6 - 2*i] &&  a[i]) h = 1'b0;
      end
      y = y | h;
    end
    return y;
  endfunction

  function automatic logic model_s(input logic [2:0] a);
    logic y = 1'b0;
    for (int k = 0; k < 2; k++) begin
      logic h = ms_valid[k];
      for (int i = 0; i < 3; i++) begin
        if (ms_term[k][5 - 2*i] && !a[i]) h = 1'b0;
        if (ms_term[k][4 - 2*i] &&  a[i]) h = 1'b0;
      end
      y = y | h;
    end
    return y;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin mb_term[k] = '0; mb_valid[k] = 0; end
      for (int k = 0; k < 2; k++) begin ms_term[k] = '0; ms_valid[k] = 0; end
      exp_b = 1'b0;
    end else begin
      exp_b = model_b(b_a);
      if (b_we && b_addr < 3'd5) begin
        mb_term[b_addr]  = b_data;
        mb_valid[b_addr] = b_valid;
      end
      if (s_we) begin
        ms_term[s_addr]  = s_data;
        ms_valid[s_addr] = s_valid;
      end
    end
  end

  // per-clock comparison against the model (R1, R9)
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (b_y !== exp_b) begin
        failures++;
        $display("FAIL R1/R9 model compare big: actual=%b expected=%b a=%h", b_y, exp_b, b_a);
      end
      checks++;
      if (s_y !== model_s(s_a)) begin
        failures++;
        $display("FAIL R1/R9 model compare small: actual=%b expected=%b a=%h", s_y, model_s(s_a), s_a);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_b(input int addr, input logic v, input logic [7:0] d);
    b_we = 1'b1; b_addr = 3'(addr); b_valid = v; b_data = d;
    step();
    b_we = 1'b0;
  endtask

  task automatic wr_s(input int addr, input logic v, input logic [5:0] d);
    s_we = 1'b1; s_addr = 1'(addr); s_valid = v; s_data = d;
    step();
    s_we = 1'b0;
  endtask

  task automatic clear_b();
    for (int k = 0; k < 5; k++) wr_b(k, 1'b0, 8'h00);
  endtask

  // apply a, wait for the registered output, check at the following negedge
  task automatic probe_b(input string tag, input int a, input logic exp);
    b_a = 4'(a);
    step();
    @(negedge clk);
    check(tag, b_y, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    b_we = 0; b_addr = 0; b_valid = 0; b_data = 0; b_a = 0;
    s_we = 0; s_addr = 0; s_valid = 0; s_data = 0; s_a = 0;
    cmp_en = 1'b1;
    repeat (3) step();
    @(negedge clk);
    check("R8 reset big", b_y, 1'b0);
    check("R8 reset small", s_y, 1'b0);
    step();
    rst_n = 1'b1;

    // R8 / R5: cleared table gives 0 everywhere
    for (int a = 0; a < 16; a++) probe_b("R8 cleared table", a, 1'b0);

    // R2: example function on the small instance
    wr_s(0, 1'b1, 6'b010000);
    wr_s(1, 1'b1, 6'b001001);
    for (int a = 0; a < 8; a++) begin
      logic [2:0] av = 3'(a);
      s_a = av;
      #2;
      check("R2 example table", s_y, ~av[0] | (av[1] & ~av[2]));
      step();
    end

    // R3: empty valid term
    clear_b();
    wr_b(0, 1'b1, 8'h00);
    for (int a = 0; a < 16; a++) probe_b("R3 empty term", a, 1'b1);

    // R4: both polarities of input 2
    clear_b();
    wr_b(1, 1'b1, 8'b0000_1100);
    for (int a = 0; a < 16; a++) probe_b("R4 contradiction", a, 1'b0);

    // R5: invalid empty term
    clear_b();
    wr_b(3, 1'b0, 8'h00);
    for (int a = 0; a < 16; a++) probe_b("R5 invalid term", a, 1'b0);

    // R7: out-of-range addresses with an always-true word
    clear_b();
    wr_b(5, 1'b1, 8'h00);
    wr_b(6, 1'b1, 8'h00);
    wr_b(7, 1'b1, 8'h00);
    for (int a = 0; a < 16; a++) probe_b("R7 out of range", a, 1'b0);

    // R6: one write leaves the neighbour term intact
    clear_b();
    wr_b(2, 1'b1, 8'b1000_0000);  // a[0]
    wr_b(3, 1'b1, 8'b0010_0000);  // a[1]
    probe_b("R6 term2 live", 1, 1'b1);
    probe_b("R6 term3 live", 2, 1'b1);
    probe_b("R6 none", 0, 1'b0);
    wr_b(3, 1'b0, 8'b0010_0000);
    probe_b("R6 term2 kept", 1, 1'b1);
    probe_b("R6 term3 gone", 2, 1'b0);

    // R9: one-cycle latency of the registered output
    clear_b();
    wr_b(0, 1'b1, 8'b1000_0000);
    b_a = 4'h0;
    step(); step();
    b_a = 4'h1;
    @(negedge clk);
    check("R9 before edge", b_y, 1'b0);
    @(negedge clk);
    check("R9 after edge", b_y, 1'b1);
    step();

    // R1: random tables, full input sweeps
    for (int t = 0; t < 25; t++) begin
      for (int k = 0; k < 5; k++)
        wr_b(k, 1'(($urandom % 4) != 0), 8'($urandom));
      for (int a = 0; a < 16; a++) begin b_a = 4'(a); step(); end
    end
    for (int t = 0; t < 15; t++) begin
      for (int k = 0; k < 2; k++)
        wr_s(k, 1'(($urandom % 4) != 0), 6'($urandom));
      for (int a = 0; a < 8; a++) begin s_a = 3'(a); step(); end
    end

    step(); step();
    @(negedge clk);
    cmp_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule